// File: doc/BRIEF.md
# Coherent Request Type Selector

This block sits beside a write-back cache on the requesting side of a coherent interconnect. For each local cache event it works out which coherent bus transaction the event needs. The events are a load miss, a store covering the whole line, a store covering part of the line, an eviction, and an eager clean of a line that stays cached. The choice depends on the line's present state, on whether the address is shareable, and on a configuration input. That input names the fill request this cache may use.

The selected request is shown for one cycle on the read or the write request channel. The block then waits for the completion pulse. One cycle after the completion it reports the line's new state. Events that need no bus traffic report their new state one cycle after the event, with no request. Data movement and the tag/data arrays stay outside the block. The owning cache controller holds back new events while `busy` is high.

Top module: `coh_req_sel`

## Requirements
- R1: After reset `busy`, `rd_valid`, `wr_valid` and `upd_valid` are low, and both request code outputs read 0.
- R2: Line states are encoded as Invalid=0, SharedClean=1, SharedDirty=2, UniqueClean=3, UniqueDirty=4. Event kinds are load=0, full store=1, partial store=2, evict=3, clean=4. For a non-shareable event (`ev_share`=0) the behaviour is as follows:
  - A load to an Invalid line issues read-no-snoop (code 1) and fills UniqueClean.
  - A partial store to an Invalid line issues read-no-snoop and ends UniqueDirty.
  - A dirty eviction or a dirty clean issues write-no-snoop (code 8).
  - A full store, or a store to a held line, is silent and ends UniqueDirty.
  - A clean eviction is silent and ends Invalid.
- R3: A shareable load to an Invalid line issues a read-channel fill chosen by `rd_policy`: 0 gives read-shared (code 2), 1 gives read-not-shared-dirty (code 4), and 2 or 3 give read-clean (code 3).
- R4: A shareable full store to a line in Invalid, SharedClean or SharedDirty issues make-unique (code 7) on the read channel. The line ends UniqueDirty.
- R5: A shareable partial store issues on the read channel. An Invalid line gets read-unique (code 5) and a SharedClean or SharedDirty line gets clean-unique (code 6). Either way the line ends UniqueDirty.
- R6: A store of either kind to a UniqueClean or UniqueDirty line issues no request and reports UniqueDirty one cycle after the event.
- R7: A shareable eviction issues on the write channel. A SharedDirty or UniqueDirty line gets write-back (code 9) and a SharedClean or UniqueClean line gets the data-less evict notice (code 11). Either way the line ends Invalid. Evicting an Invalid line is silent and reports Invalid.
- R8: A shareable clean issues write-clean (code 10) on the write channel for a dirty line. SharedDirty then ends SharedClean, and UniqueDirty ends UniqueClean. Cleaning a clean or Invalid line is silent and keeps the state.
- R9: The state after a fill depends on the completion flags `cpl_shared` and `cpl_dirty`:
  - Read-shared gives SharedDirty, SharedClean, UniqueDirty or UniqueClean according to the two flags.
  - Read-not-shared-dirty gives SharedClean whenever `cpl_shared` is set.
  - Read-clean never gives a dirty state.
  - Read-no-snoop always gives UniqueClean.
- R10: A request appears one cycle after its event is sampled and lasts exactly one cycle. `busy` is high from the request until a completion is sampled. `upd_valid` pulses one cycle after that completion.
- R11: Events sampled while `busy` is high, and completions sampled while `busy` is low, cause no request and no update.
- R12: A load to a line that is already held (not Invalid) is silent and reports the unchanged state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Cache event present this cycle |
| ev_kind | input | 3 | Event kind (R2 encoding) |
| ev_state | input | 3 | Current state of the addressed line |
| ev_share | input | 1 | Address is shareable |
| rd_policy | input | 2 | Fill request this cache may use (R3) |
| cpl_valid | input | 1 | Outstanding request completed |
| cpl_shared | input | 1 | Completion reports the line as shared |
| cpl_dirty | input | 1 | Completion passes write-back responsibility |
| rd_valid | output | 1 | Read-channel request pulse |
| rd_code | output | 4 | Read-channel request code, 0 when idle |
| wr_valid | output | 1 | Write-channel request pulse |
| wr_code | output | 4 | Write-channel request code, 0 when idle |
| busy | output | 1 | A request is outstanding |
| upd_valid | output | 1 | New line state is reported |
| upd_state | output | 3 | New line state (R2 encoding) |

## Verification
The hardest situation to reach from the ports is the interplay of the outstanding window with stray inputs. A new event can arrive while a request waits for completion, and a completion can arrive when nothing is outstanding. The bench opens a write-back window with a dirty eviction and holds the completion back. During that window it drives a load miss that would otherwise issue a read. It checks that no request or update appears and that the final state follows the first event only. It then pulses the completion while idle and watches for a spurious update. The fill-result filtering is reached by pairing each fill policy with completion flag combinations that the policy forbids.

// File: rtl/coh_req_sel_pkg.sv
package coh_req_sel_pkg;

    localparam int STATE_W = 3;
    localparam int KIND_W  = 3;
    localparam int CODE_W  = 4;
    localparam int POL_W   = 2;

    typedef enum logic [STATE_W-1:0] {
        LS_INV = 3'd0,
        LS_SC  = 3'd1,
        LS_SD  = 3'd2,
        LS_UC  = 3'd3,
        LS_UD  = 3'd4
    } line_st_e;

    typedef enum logic [KIND_W-1:0] {
        EV_LOAD       = 3'd0,
        EV_STORE_FULL = 3'd1,
        EV_STORE_PART = 3'd2,
        EV_EVICT      = 3'd3,
        EV_CLEAN      = 3'd4
    } ev_kind_e;

    typedef enum logic [CODE_W-1:0] {
        RQ_NONE      = 4'd0,
        RQ_RD_NOSNP  = 4'd1,
        RQ_RD_SHARED = 4'd2,
        RQ_RD_CLEAN  = 4'd3,
        RQ_RD_NSD    = 4'd4,
        RQ_RD_UNIQ   = 4'd5,
        RQ_CLN_UNIQ  = 4'd6,
        RQ_MK_UNIQ   = 4'd7,
        RQ_WR_NOSNP  = 4'd8,
        RQ_WR_BACK   = 4'd9,
        RQ_WR_CLEAN  = 4'd10,
        RQ_EVICT     = 4'd11
    } req_code_e;

    typedef enum logic [1:0] {
        CH_NONE = 2'd0,
        CH_RD   = 2'd1,
        CH_WR   = 2'd2
    } chan_e;

    typedef struct packed {
        chan_e     chan;
        req_code_e code;
        line_st_e  nxt;
        logic      fill;
    } plan_t;

endpackage

// File: rtl/coh_req_decode.sv
module coh_req_decode
    import coh_req_sel_pkg::*;
(
    input  logic [KIND_W-1:0]  kind,
    input  logic [STATE_W-1:0] state,
    input  logic               share,
    input  logic [POL_W-1:0]   policy,
    output plan_t              plan
);

    function automatic plan_t mk(chan_e c, req_code_e k, line_st_e n, logic f);
        plan_t p;
        p.chan = c;
        p.code = k;
        p.nxt  = n;
        p.fill = f;
        return p;
    endfunction

    line_st_e  cur;
    req_code_e fill_code;
    logic      held;
    logic      dirty;
    logic      uniq;

    always_comb begin
        case (state)
            3'd1:    cur = LS_SC;
            3'd2:    cur = LS_SD;
            3'd3:    cur = LS_UC;
            3'd4:    cur = LS_UD;
            default: cur = LS_INV;
        endcase
        held  = (cur != LS_INV);
        dirty = (cur == LS_SD) || (cur == LS_UD);
        uniq  = (cur == LS_UC) || (cur == LS_UD);

        case (policy)
            2'd0:    fill_code = RQ_RD_SHARED;
            2'd1:    fill_code = RQ_RD_NSD;
            default: fill_code = RQ_RD_CLEAN;
        endcase

        plan = mk(CH_NONE, RQ_NONE, cur, 1'b0);
        case (kind)
            EV_LOAD: begin
                if (!held) begin
                    plan = mk(CH_RD, share ? fill_code : RQ_RD_NOSNP, LS_UC, 1'b1);
                end
            end
            EV_STORE_FULL: begin
                if (!share || uniq) begin
                    plan = mk(CH_NONE, RQ_NONE, LS_UD, 1'b0);
                end else begin
                    plan = mk(CH_RD, RQ_MK_UNIQ, LS_UD, 1'b0);
                end
            end
            EV_STORE_PART: begin
                if (uniq || (!share && held)) begin
                    plan = mk(CH_NONE, RQ_NONE, LS_UD, 1'b0);
                end else if (!held) begin
                    plan = mk(CH_RD, share ? RQ_RD_UNIQ : RQ_RD_NOSNP, LS_UD, 1'b0);
                end else begin
                    plan = mk(CH_RD, RQ_CLN_UNIQ, LS_UD, 1'b0);
                end
            end
            EV_EVICT: begin
                if (dirty) begin
                    plan = mk(CH_WR, share ? RQ_WR_BACK : RQ_WR_NOSNP, LS_INV, 1'b0);
                end else if (held && share) begin
                    plan = mk(CH_WR, RQ_EVICT, LS_INV, 1'b0);
                end else begin
                    plan = mk(CH_NONE, RQ_NONE, LS_INV, 1'b0);
                end
            end
            EV_CLEAN: begin
                if (dirty) begin
                    plan = mk(CH_WR, share ? RQ_WR_CLEAN : RQ_WR_NOSNP,
                              (cur == LS_SD) ? LS_SC : LS_UC, 1'b0);
                end
            end
            default: plan = mk(CH_NONE, RQ_NONE, cur, 1'b0);
        endcase
    end

endmodule

// File: rtl/coh_fill_resolve.sv
module coh_fill_resolve
    import coh_req_sel_pkg::*;
(
    input  req_code_e code,
    input  logic      shared,
    input  logic      dirty,
    output line_st_e  result
);

    logic sh_ok;
    logic dt_ok;

    always_comb begin
        sh_ok = shared;
        dt_ok = dirty;
        case (code)
            RQ_RD_SHARED: begin
                sh_ok = shared;
                dt_ok = dirty;
            end
            RQ_RD_NSD: begin
                sh_ok = shared;
                dt_ok = dirty && !shared;
            end
            RQ_RD_CLEAN: begin
                sh_ok = shared;
                dt_ok = 1'b0;
            end
            default: begin
                sh_ok = 1'b0;
                dt_ok = 1'b0;
            end
        endcase

        if (sh_ok) begin
            result = dt_ok ? LS_SD : LS_SC;
        end else begin
            result = dt_ok ? LS_UD : LS_UC;
        end
    end

endmodule

// File: rtl/coh_req_seq.sv
module coh_req_seq
    import coh_req_sel_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ev_valid,
    input  plan_t     plan,
    input  logic      cpl_valid,
    input  line_st_e  fill_state,
    output logic      rd_v,
    output logic      wr_v,
    output req_code_e req_code,
    output logic      busy,
    output logic      upd_v,
    output line_st_e  upd_st
);

    typedef struct packed {
        logic      busy;
        logic      rd_v;
        logic      wr_v;
        req_code_e code;
        logic      upd_v;
        line_st_e  upd_st;
        line_st_e  pend_nxt;
        logic      pend_fill;
    } seq_t;

    localparam seq_t SEQ_RST = '{
        busy:      1'b0,
        rd_v:      1'b0,
        wr_v:      1'b0,
        code:      RQ_NONE,
        upd_v:     1'b0,
        upd_st:    LS_INV,
        pend_nxt:  LS_INV,
        pend_fill: 1'b0
    };

    seq_t s_d;
    seq_t s_q;

    always_comb begin
        s_d       = s_q;
        s_d.rd_v  = 1'b0;
        s_d.wr_v  = 1'b0;
        s_d.upd_v = 1'b0;
        if (!s_q.busy) begin
            if (ev_valid) begin
                if (plan.chan == CH_NONE) begin
                    s_d.upd_v  = 1'b1;
                    s_d.upd_st = plan.nxt;
                end else begin
                    s_d.busy      = 1'b1;
                    s_d.rd_v      = (plan.chan == CH_RD);
                    s_d.wr_v      = (plan.chan == CH_WR);
                    s_d.code      = plan.code;
                    s_d.pend_nxt  = plan.nxt;
                    s_d.pend_fill = plan.fill;
                end
            end
        end else if (cpl_valid) begin
            s_d.busy   = 1'b0;
            s_d.upd_v  = 1'b1;
            s_d.upd_st = s_q.pend_fill ? fill_state : s_q.pend_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= SEQ_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_v     = s_q.rd_v;
    assign wr_v     = s_q.wr_v;
    assign req_code = s_q.code;
    assign busy     = s_q.busy;
    assign upd_v    = s_q.upd_v;
    assign upd_st   = s_q.upd_st;

endmodule

// File: rtl/coh_req_sel.sv
module coh_req_sel
    import coh_req_sel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_valid,
    input  logic [KIND_W-1:0]  ev_kind,
    input  logic [STATE_W-1:0] ev_state,
    input  logic               ev_share,
    input  logic [POL_W-1:0]   rd_policy,
    input  logic               cpl_valid,
    input  logic               cpl_shared,
    input  logic               cpl_dirty,
    output logic               rd_valid,
    output logic [CODE_W-1:0]  rd_code,
    output logic               wr_valid,
    output logic [CODE_W-1:0]  wr_code,
    output logic               busy,
    output logic               upd_valid,
    output logic [STATE_W-1:0] upd_state
);

    plan_t     plan;
    line_st_e  fill_st;
    req_code_e cur_code;
    line_st_e  upd_st;
    logic      rd_v;
    logic      wr_v;

    coh_req_decode u_decode (
        .kind   (ev_kind),
        .state  (ev_state),
        .share  (ev_share),
        .policy (rd_policy),
        .plan   (plan)
    );

    coh_fill_resolve u_fill (
        .code   (cur_code),
        .shared (cpl_shared),
        .dirty  (cpl_dirty),
        .result (fill_st)
    );

    coh_req_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .plan       (plan),
        .cpl_valid  (cpl_valid),
        .fill_state (fill_st),
        .rd_v       (rd_v),
        .wr_v       (wr_v),
        .req_code   (cur_code),
        .busy       (busy),
        .upd_v      (upd_valid),
        .upd_st     (upd_st)
    );

    assign rd_valid  = rd_v;
    assign wr_valid  = wr_v;
    assign rd_code   = rd_v ? cur_code : RQ_NONE;
    assign wr_code   = wr_v ? cur_code : RQ_NONE;
    assign upd_state = upd_st;

endmodule

// File: rtl/coh_req_sel_chk.sv
module coh_req_sel_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ev_valid,
    input logic [2:0] ev_kind,
    input logic [2:0] ev_state,
    input logic       ev_share,
    input logic [1:0] rd_policy,
    input logic       cpl_valid,
    input logic       cpl_shared,
    input logic       cpl_dirty,
    input logic       rd_valid,
    input logic [3:0] rd_code,
    input logic       wr_valid,
    input logic [3:0] wr_code,
    input logic       busy,
    input logic       upd_valid,
    input logic [2:0] upd_state
);

    // R10
    chan_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_valid}));

    // R10
    req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |=> !(rd_valid || wr_valid));

    // R10
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_valid) |-> busy);

    // R5
    rd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_code >= 4'd1 && rd_code <= 4'd7));

    // R7
    wr_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_code >= 4'd8 && wr_code <= 4'd11));

    // R10
    cpl_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpl_valid) |=> (upd_valid && !busy));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cpl_valid) |=> (busy && !rd_valid && !wr_valid && !upd_valid));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ev_valid) |=> (!upd_valid && !rd_valid && !wr_valid));

    // R2
    upd_enc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid |-> (upd_state <= 3'd4));

endmodule

bind coh_req_sel coh_req_sel_chk chk_i (.*);

// File: tb/coh_req_sel_tb_top.sv
module coh_req_sel_tb_top;

    localparam int CLK_P  = 10;
    localparam int NVEC   = 28;
    localparam int WDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [2:0] ev_kind = 3'd0;
    logic [2:0] ev_state = 3'd0;
    logic       ev_share = 1'b0;
    logic [1:0] rd_policy = 2'd0;
    logic       cpl_valid = 1'b0;
    logic       cpl_shared = 1'b0;
    logic       cpl_dirty = 1'b0;
    logic       rd_valid;
    logic [3:0] rd_code;
    logic       wr_valid;
    logic [3:0] wr_code;
    logic       busy;
    logic       upd_valid;
    logic [2:0] upd_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    coh_req_sel dut_i (.*);

    // Fields: share kind state policy chan code cpl_sh cpl_dt next (20 bits)
    localparam logic [19:0] TBL [NVEC] = '{
        {1'b1, 3'd0, 3'd0, 2'd0, 2'd1, 4'd2,  1'b0, 1'b0, 3'd3},
        {1'b1, 3'd0, 3'd0, 2'd1, 2'd1, 4'd4,  1'b1, 1'b1, 3'd1},
        {1'b1, 3'd0, 3'd0, 2'd2, 2'd1, 4'd3,  1'b0, 1'b1, 3'd3},
        {1'b1, 3'd0, 3'd0, 2'd0, 2'd1, 4'd2,  1'b1, 1'b1, 3'd2},
        {1'b1, 3'd0, 3'd0, 2'd1, 2'd1, 4'd4,  1'b0, 1'b1, 3'd4},
        {1'b1, 3'd1, 3'd1, 2'd0, 2'd1, 4'd7,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd1, 3'd0, 2'd0, 2'd1, 4'd7,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd2, 3'd0, 2'd0, 2'd1, 4'd5,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd2, 3'd2, 2'd0, 2'd1, 4'd6,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd2, 3'd1, 2'd0, 2'd1, 4'd6,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd1, 3'd3, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd2, 3'd4, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd4},
        {1'b1, 3'd3, 3'd2, 2'd0, 2'd2, 4'd9,  1'b0, 1'b0, 3'd0},
        {1'b1, 3'd3, 3'd4, 2'd0, 2'd2, 4'd9,  1'b0, 1'b0, 3'd0},
        {1'b1, 3'd3, 3'd1, 2'd0, 2'd2, 4'd11, 1'b0, 1'b0, 3'd0},
        {1'b1, 3'd3, 3'd3, 2'd0, 2'd2, 4'd11, 1'b0, 1'b0, 3'd0},
        {1'b1, 3'd4, 3'd2, 2'd0, 2'd2, 4'd10, 1'b0, 1'b0, 3'd1},
        {1'b1, 3'd4, 3'd4, 2'd0, 2'd2, 4'd10, 1'b0, 1'b0, 3'd3},
        {1'b1, 3'd4, 3'd1, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd1},
        {1'b1, 3'd0, 3'd1, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd1},
        {1'b0, 3'd0, 3'd0, 2'd0, 2'd1, 4'd1,  1'b1, 1'b1, 3'd3},
        {1'b0, 3'd2, 3'd0, 2'd0, 2'd1, 4'd1,  1'b0, 1'b0, 3'd4},
        {1'b0, 3'd1, 3'd1, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd4},
        {1'b0, 3'd3, 3'd4, 2'd0, 2'd2, 4'd8,  1'b0, 1'b0, 3'd0},
        {1'b0, 3'd3, 3'd3, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd0},
        {1'b0, 3'd4, 3'd4, 2'd0, 2'd2, 4'd8,  1'b0, 1'b0, 3'd3},
        {1'b1, 3'd3, 3'd0, 2'd0, 2'd0, 4'd0,  1'b0, 1'b0, 3'd0},
        {1'b1, 3'd0, 3'd0, 2'd3, 2'd1, 4'd3,  1'b1, 1'b1, 3'd1}
    };

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic sh, input logic [2:0] kind,
                                     input logic [2:0] st, input logic [1:0] ch);
        if (!sh)                      return "R2";
        if (kind == 3'd0 && st != 3'd0) return "R12";
        if (kind == 3'd0)             return "R3";
        if (ch == 2'd0 && kind <= 3'd2) return "R6";
        if (kind == 3'd1)             return "R4";
        if (kind == 3'd2)             return "R5";
        if (kind == 3'd3)             return "R7";
        return "R8";
    endfunction

    task automatic run_vec(input logic [19:0] v);
        logic       sh   = v[19];
        logic [2:0] kind = v[18:16];
        logic [2:0] st   = v[15:13];
        logic [1:0] pol  = v[12:11];
        logic [1:0] ch   = v[10:9];
        logic [3:0] code = v[8:5];
        logic       csh  = v[4];
        logic       cdt  = v[3];
        logic [2:0] nst  = v[2:0];
        string      tg   = tag_of(sh, kind, st, ch);
        ev_share  = sh;
        ev_kind   = kind;
        ev_state  = st;
        rd_policy = pol;
        ev_valid  = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check(tg, "rd_valid", rd_valid, (ch == 2'd1));
        check(tg, "wr_valid", wr_valid, (ch == 2'd2));
        if (ch == 2'd1) check(tg, "rd_code", rd_code, code);
        if (ch == 2'd2) check(tg, "wr_code", wr_code, code);
        if (ch == 2'd0) begin
            check(tg, "silent upd_valid", upd_valid, 1);
            check(tg, "silent upd_state", upd_state, nst);
        end else begin
            check("R10", "busy after request", busy, 1);
            check("R10", "no early update", upd_valid, 0);
            cpl_valid  = 1'b1;
            cpl_shared = csh;
            cpl_dirty  = cdt;
            @(negedge clk);
            cpl_valid = 1'b0;
            check("R10", "request lasts one cycle", rd_valid | wr_valid, 0);
            check("R10", "update after completion", upd_valid, 1);
            check((kind == 3'd0 && sh) ? "R9" : tg, "upd_state", upd_state, nst);
            check("R10", "busy clears", busy, 0);
        end
        @(negedge clk);
        check("R10", "update is a pulse", upd_valid, 0);
    endtask

    initial begin
        #(CLK_P * WDOG);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "busy", busy, 0);
        check("R1", "rd_valid", rd_valid, 0);
        check("R1", "wr_valid", wr_valid, 0);
        check("R1", "upd_valid", upd_valid, 0);
        check("R1", "rd_code", rd_code, 0);
        check("R1", "wr_code", wr_code, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            run_vec(TBL[i]);
        end

        // R11: event while busy is ignored
        ev_share = 1'b1; ev_kind = 3'd3; ev_state = 3'd4; rd_policy = 2'd0;
        ev_valid = 1'b1;
        @(negedge clk);
        check("R11", "write-back issued", wr_code, 9);
        ev_kind = 3'd0; ev_state = 3'd0;
        @(negedge clk);
        ev_valid = 1'b0;
        check("R11", "no read while busy", rd_valid, 0);
        check("R11", "no update while busy", upd_valid, 0);
        check("R11", "still busy", busy, 1);
        @(negedge clk);
        check("R11", "no late read", rd_valid, 0);
        cpl_valid = 1'b1; cpl_shared = 1'b1; cpl_dirty = 1'b1;
        @(negedge clk);
        cpl_valid = 1'b0;
        check("R11", "state follows first event", upd_state, 0);
        check("R11", "update valid", upd_valid, 1);
        @(negedge clk);

        // R11: completion while idle is ignored
        cpl_valid = 1'b1;
        @(negedge clk);
        cpl_valid = 1'b0;
        check("R11", "idle completion no update", upd_valid, 0);
        check("R11", "idle completion no busy", busy, 0);
        @(negedge clk);

        // R6: back-to-back silent stores
        ev_share = 1'b1; ev_kind = 3'd2; ev_state = 3'd3; ev_valid = 1'b1;
        @(negedge clk);
        check("R6", "first silent upd", upd_valid, 1);
        ev_kind = 3'd1; ev_state = 3'd4;
        @(negedge clk);
        ev_valid = 1'b0;
        check("R6", "second silent upd", upd_valid, 1);
        check("R6", "second silent state", upd_state, 4);
        check("R6", "no request", rd_valid | wr_valid, 0);
        @(negedge clk);

        // R1: reset in the middle of a pending request
        ev_kind = 3'd1; ev_state = 3'd1; ev_valid = 1'b1;
        @(negedge clk);
        ev_valid = 1'b0;
        check("R4", "make-unique pending", busy, 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "busy cleared by reset", busy, 0);
        check("R1", "no update after reset", upd_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule